// File: doc/BRIEF.md
# Flash Sector-Protection Command Sequencer

This block models the protection-command front end of a 32-bit-wide flash device. It watches host write cycles (address, data, strobe) and decodes command sequences that begin with an unlock prefix. Those sequences change a set of protection bits:

- a persistent protect bit for each sector
- a dynamic protect bit for each sector
- a lock that freezes the persistent bits
- a secured-region protect bit
- two mutually exclusive mode-lock bits
- a 64-bit password held as two 32-bit halves

Status comes back on a read port, one cycle after the read strobe. The data returned depends on which status mode the last command sequence left the decoder in.

Each sector has a write-protect output. It is the OR of that sector's persistent and dynamic bits. The storage array, program and erase timing, and burst reads are not modelled.

Top module: `flash_prot_seq`

## Requirements
- R1: A command begins with two exact writes: low byte AAh with address bits [10:0] equal to 555h, then low byte 55h at 2AAh. A third write at 555h carries the command code. Any mismatch returns the decoder to idle, and no protection bit changes.
- R2: During the prefix, address bits above bit 10 and data bits above bit 7 are ignored.
- R3: A write whose low byte is F0h aborts any partial sequence and returns the decoder to idle, which reads as 0. In a cycle that expects an operand (dynamic-bit data, password data), F0h is taken as data instead.
- R4: Address bits [5:0] pick the target, with bit 2 ignored: 011x10 is the secured-region bit, 001x10 the password-mode lock, 010x10 the persistent-mode lock, 111x10 a persistent bit. The sector number is address bits [18:11].
- R5: Command 60h, then 68h to a target, then 48h to the identical address, sets that target bit. If the address of the 48h write differs, nothing changes.
- R6: After a program or erase sequence, each read returns, in bit 0, the bit named by the read address. All other bits are 0.
- R7: Command 60h, then 60h to a persistent-bit address, then 40h to a persistent-bit address, clears every persistent bit.
- R8: After command 90h, each read returns 00h if the addressed sector's persistent bit is set and 01h if it is clear. Reads may repeat for any number of sectors.
- R9: Command 48h, then one write to a sector address, sets that sector's dynamic bit to data bit 0. After command 58h, reads return the addressed dynamic bit in bit 0.
- R10: sec_wp[s] equals persistent[s] OR dynamic[s]. It reflects a write from the clock edge that accepts the write onward, and changes only on writes.
- R11: Command 78h sets the persistent lock. While the lock is set, persistent program and erase have no effect. Reset or a password unlock clears the lock.
- R12: Once one mode-lock bit is set, the other cannot be set. In password mode, password verify reads return 0 and password program is ignored.
- R13: Command 38h programs the password half selected by address bit 0, and C8h reads that half back. Command 28h compares one half. In password mode, the lock clears once both halves have matched with no mismatch in between.
- R14: rd_data loads one cycle after rd_en, from the mode and bits in place before any write in the same cycle. When the decoder is not in a status mode, the read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes are captured on its rising edge |
| rst_n | input | 1 | Active-low reset, clears every bit and the decoder |
| wr_en | input | 1 | Write-cycle strobe |
| wr_addr | input | 19 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read-cycle strobe |
| rd_addr | input | 19 | Read address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| sec_wp | output | 256 | Per-sector write-protect flags |

## Verification
A read and a write can fall in the same cycle. Such a read must see the mode in place before the write. The bench drives a read strobe together with the final 48h program write, and expects 0 from the pending state, then 1 on the next read. It also drives a read together with an F0h abort while in persistent-status mode, and expects the status code, then 0 once the decoder is idle. A scoreboard queue holds each expected value until the read data for it arrives.

// File: rtl/fps_pkg.sv
package fps_pkg;

   localparam logic [10:0] LO_FIRST  = 11'h555;
   localparam logic [10:0] LO_SECOND = 11'h2AA;
   localparam logic [7:0]  KEY_FIRST  = 8'hAA;
   localparam logic [7:0]  KEY_SECOND = 8'h55;
   localparam logic [7:0]  OP_ABORT   = 8'hF0;
   localparam logic [7:0]  OP_PERS    = 8'h60;
   localparam logic [7:0]  OP_ARM     = 8'h68;
   localparam logic [7:0]  OP_COMMIT  = 8'h48;
   localparam logic [7:0]  OP_WIPE    = 8'h40;
   localparam logic [7:0]  OP_DYN_WR  = 8'h48;
   localparam logic [7:0]  OP_DYN_RD  = 8'h58;
   localparam logic [7:0]  OP_PERS_RD = 8'h90;
   localparam logic [7:0]  OP_FREEZE  = 8'h78;
   localparam logic [7:0]  OP_PW_WR   = 8'h38;
   localparam logic [7:0]  OP_PW_RD   = 8'hC8;
   localparam logic [7:0]  OP_PW_CMP  = 8'h28;

   typedef enum logic [3:0] {
      ST_IDLE, ST_UNL1, ST_UNL2, ST_PERS, ST_PPROG, ST_PERASE, ST_VERIFY,
      ST_PSTAT, ST_DWR, ST_DSTAT, ST_PWPROG, ST_PWVER, ST_PWUNLK
   } seq_state_t;

   typedef enum logic [2:0] {
      TG_NONE, TG_SSP, TG_PWML, TG_PSML, TG_PPB
   } tgt_t;

   typedef struct packed {
      logic pers_set;
      logic ppb_erase;
      logic lock_set;
      logic dyb_wr;
      logic pw_wr;
      logic pw_cmp;
   } act_t;

   function automatic tgt_t tgt_decode(input logic [5:0] lo);
      tgt_t t;
      t = TG_NONE;
      if (lo[1:0] == 2'b10) begin
         case (lo[5:3])
            3'b011:  t = TG_SSP;
            3'b001:  t = TG_PWML;
            3'b010:  t = TG_PSML;
            3'b111:  t = TG_PPB;
            default: t = TG_NONE;
         endcase
      end
      return t;
   endfunction

endpackage

// File: rtl/fps_decoder.sv
module fps_decoder
   import fps_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 32,
   parameter int SECT_LSB = 11,
   parameter int SECT_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output seq_state_t        state_o,
   output act_t              act_o,
   output tgt_t              tgt_o,
   output logic [SECT_W-1:0] sect_o,
   output logic              bit_o,
   output logic              half_o,
   output logic [DATA_W-1:0] data_o
);

   seq_state_t        state_q, state_d;
   logic [ADDR_W-1:0] held_q;
   logic [10:0]       lo;
   logic [7:0]        op;
   tgt_t              tgt;
   logic              operand_slot;
   logic              abort;

   assign lo           = wr_addr[10:0];
   assign op           = wr_data[7:0];
   assign tgt          = tgt_decode(wr_addr[5:0]);
   assign operand_slot = (state_q == ST_DWR) || (state_q == ST_PWPROG) ||
                         (state_q == ST_PWUNLK);
   assign abort        = (op == OP_ABORT) && !operand_slot;

   always_comb begin
      state_d = state_q;
      act_o   = '0;
      if (wr_en) begin
         if (abort) begin
            state_d = ST_IDLE;
         end else begin
            case (state_q)
               ST_UNL1:
                  state_d = (lo == LO_SECOND && op == KEY_SECOND) ? ST_UNL2 : ST_IDLE;
               ST_UNL2: begin
                  state_d = ST_IDLE;
                  if (lo == LO_FIRST) begin
                     case (op)
                        OP_PERS:    state_d = ST_PERS;
                        OP_DYN_WR:  state_d = ST_DWR;
                        OP_DYN_RD:  state_d = ST_DSTAT;
                        OP_PERS_RD: state_d = ST_PSTAT;
                        OP_FREEZE:  act_o.lock_set = 1'b1;
                        OP_PW_WR:   state_d = ST_PWPROG;
                        OP_PW_RD:   state_d = ST_PWVER;
                        OP_PW_CMP:  state_d = ST_PWUNLK;
                        default:    state_d = ST_IDLE;
                     endcase
                  end
               end
               ST_PERS: begin
                  if (op == OP_ARM && tgt != TG_NONE)
                     state_d = ST_PPROG;
                  else if (op == OP_PERS && tgt == TG_PPB)
                     state_d = ST_PERASE;
                  else
                     state_d = ST_IDLE;
               end
               ST_PPROG: begin
                  if (op == OP_COMMIT && wr_addr == held_q) begin
                     act_o.pers_set = 1'b1;
                     state_d        = ST_VERIFY;
                  end else begin
                     state_d = ST_IDLE;
                  end
               end
               ST_PERASE: begin
                  if (op == OP_WIPE && tgt == TG_PPB) begin
                     act_o.ppb_erase = 1'b1;
                     state_d         = ST_VERIFY;
                  end else begin
                     state_d = ST_IDLE;
                  end
               end
               ST_DWR: begin
                  act_o.dyb_wr = 1'b1;
                  state_d      = ST_IDLE;
               end
               ST_PWPROG: begin
                  act_o.pw_wr = 1'b1;
                  state_d     = ST_IDLE;
               end
               ST_PWUNLK: begin
                  act_o.pw_cmp = 1'b1;
                  state_d      = ST_IDLE;
               end
               default:
                  state_d = (lo == LO_FIRST && op == KEY_FIRST) ? ST_UNL1 : ST_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         held_q  <= '0;
      end else begin
         state_q <= state_d;
         if (wr_en && state_q == ST_PERS)
            held_q <= wr_addr;
      end
   end

   assign state_o = state_q;
   assign tgt_o   = tgt;
   assign sect_o  = wr_addr[SECT_LSB +: SECT_W];
   assign bit_o   = wr_data[0];
   assign half_o  = wr_addr[0];
   assign data_o  = wr_data;

endmodule

// File: rtl/fps_bitstore.sv
module fps_bitstore
   import fps_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SECT_W = 8,
   localparam int NSECT = 1 << SECT_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  act_t                   act,
   input  tgt_t                   tgt,
   input  logic [SECT_W-1:0]      sect,
   input  logic                   bitv,
   input  logic                   half,
   input  logic [DATA_W-1:0]      data,
   output logic [NSECT-1:0]       ppb_o,
   output logic [NSECT-1:0]       dyb_o,
   output logic                   lock_o,
   output logic                   ssp_o,
   output logic                   pwml_o,
   output logic                   psml_o,
   output logic [2*DATA_W-1:0]    pw_o,
   output logic [NSECT-1:0]       sec_wp_o
);

   logic [1:0][DATA_W-1:0] pw_q;
   logic [1:0]             hit_q;
   logic                   lock_q, ssp_q, pwml_q, psml_q;
   logic                   cmp_eq, unlock_hit;

   assign cmp_eq     = (data == pw_q[half]);
   assign unlock_hit = act.pw_cmp && pwml_q && cmp_eq && hit_q[~half];

   for (genvar g = 0; g < NSECT; g++) begin : g_sect
      logic ppb_r, dyb_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ppb_r <= 1'b0;
            dyb_r <= 1'b0;
         end else begin
            if (act.ppb_erase && !lock_q)
               ppb_r <= 1'b0;
            else if (act.pers_set && tgt == TG_PPB && sect == SECT_W'(g) && !lock_q)
               ppb_r <= 1'b1;
            if (act.dyb_wr && sect == SECT_W'(g))
               dyb_r <= bitv;
         end
      end
      assign ppb_o[g]    = ppb_r;
      assign dyb_o[g]    = dyb_r;
      assign sec_wp_o[g] = ppb_r | dyb_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         ssp_q  <= 1'b0;
         pwml_q <= 1'b0;
         psml_q <= 1'b0;
         pw_q   <= '0;
         hit_q  <= '0;
      end else begin
         if (act.lock_set)
            lock_q <= 1'b1;
         else if (unlock_hit)
            lock_q <= 1'b0;
         if (act.pers_set) begin
            if (tgt == TG_SSP)
               ssp_q <= 1'b1;
            if (tgt == TG_PWML && !psml_q)
               pwml_q <= 1'b1;
            if (tgt == TG_PSML && !pwml_q)
               psml_q <= 1'b1;
         end
         if (act.pw_wr && !pwml_q)
            pw_q[half] <= data;
         if (act.pw_cmp) begin
            if (!cmp_eq || !pwml_q || unlock_hit)
               hit_q <= '0;
            else
               hit_q[half] <= 1'b1;
         end
      end
   end

   assign lock_o = lock_q;
   assign ssp_o  = ssp_q;
   assign pwml_o = pwml_q;
   assign psml_o = psml_q;
   assign pw_o   = pw_q;

endmodule

// File: rtl/fps_readmux.sv
module fps_readmux
   import fps_pkg::*;
#(
   parameter int  ADDR_W   = 19,
   parameter int  DATA_W   = 32,
   parameter int  SECT_LSB = 11,
   parameter int  SECT_W   = 8,
   parameter bit  PW_HIDE  = 1'b1,
   localparam int NSECT    = 1 << SECT_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   rd_addr,
   input  seq_state_t          state,
   input  logic [NSECT-1:0]    ppb,
   input  logic [NSECT-1:0]    dyb,
   input  logic                ssp,
   input  logic                pwml,
   input  logic                psml,
   input  logic [2*DATA_W-1:0] pw,
   output logic [DATA_W-1:0]   rd_data
);

   logic [SECT_W-1:0] sect;
   tgt_t              tgt;
   logic [DATA_W-1:0] pw_half, pw_val, nxt;
   logic              vbit;

   assign sect    = rd_addr[SECT_LSB +: SECT_W];
   assign tgt     = tgt_decode(rd_addr[5:0]);
   assign pw_half = rd_addr[0] ? pw[2*DATA_W-1:DATA_W] : pw[DATA_W-1:0];

   if (PW_HIDE) begin : g_hide
      assign pw_val = pwml ? '0 : pw_half;
   end else begin : g_show
      assign pw_val = pw_half;
   end

   always_comb begin
      case (tgt)
         TG_PPB:  vbit = ppb[sect];
         TG_SSP:  vbit = ssp;
         TG_PWML: vbit = pwml;
         TG_PSML: vbit = psml;
         default: vbit = 1'b0;
      endcase
   end

   always_comb begin
      nxt = '0;
      case (state)
         ST_VERIFY: nxt[0] = vbit;
         ST_PSTAT:  nxt[0] = ~ppb[sect];
         ST_DSTAT:  nxt[0] = dyb[sect];
         ST_PWVER:  nxt    = pw_val;
         default:   nxt    = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= nxt;
   end

endmodule

// File: rtl/flash_prot_seq.sv
module flash_prot_seq
   import fps_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 32,
   parameter int SECT_LSB = 11,
   parameter int SECT_W   = 8,
   parameter bit PW_HIDE  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [DATA_W-1:0]        rd_data,
   output logic [(1<<SECT_W)-1:0]   sec_wp
);

   localparam int NSECT = 1 << SECT_W;

   if (SECT_LSB < 11) begin : g_bad_lsb
      $error("sector field overlaps the unlock address bits");
   end
   if (ADDR_W < SECT_LSB + SECT_W) begin : g_bad_addr
      $error("address too narrow for the sector field");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("data bus must carry at least one byte");
   end

   seq_state_t          seq_state;
   act_t                act;
   tgt_t                tgt;
   logic [SECT_W-1:0]   sect;
   logic                bitv, half;
   logic [DATA_W-1:0]   opnd;
   logic [NSECT-1:0]    ppb_vec, dyb_vec;
   logic                lock, ssp, pwml, psml;
   logic [2*DATA_W-1:0] pw;

   fps_decoder #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB), .SECT_W(SECT_W)
   ) dec_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .state_o(seq_state), .act_o(act), .tgt_o(tgt), .sect_o(sect),
      .bit_o(bitv), .half_o(half), .data_o(opnd)
   );

   fps_bitstore #(
      .DATA_W(DATA_W), .SECT_W(SECT_W)
   ) store_i (
      .clk(clk), .rst_n(rst_n), .act(act), .tgt(tgt), .sect(sect), .bitv(bitv),
      .half(half), .data(opnd), .ppb_o(ppb_vec), .dyb_o(dyb_vec), .lock_o(lock),
      .ssp_o(ssp), .pwml_o(pwml), .psml_o(psml), .pw_o(pw), .sec_wp_o(sec_wp)
   );

   fps_readmux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB), .SECT_W(SECT_W),
      .PW_HIDE(PW_HIDE)
   ) rmux_i (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .state(seq_state),
      .ppb(ppb_vec), .dyb(dyb_vec), .ssp(ssp), .pwml(pwml), .psml(psml), .pw(pw),
      .rd_data(rd_data)
   );

endmodule

// File: rtl/fps_checker.sv
module fps_checker
   import fps_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NSECT  = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic [NSECT-1:0]  sec_wp,
   input seq_state_t        state,
   input logic [NSECT-1:0]  ppb,
   input logic              lock,
   input logic              pwml,
   input logic              psml
);

   // R10: protect flags move only on write cycles
   a_r10_wp_write_only: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(sec_wp));

   // R3: abort byte outside operand cycles returns to idle
   a_r3_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[7:0] == OP_ABORT && state != ST_DWR &&
       state != ST_PWPROG && state != ST_PWUNLK) |=> state == ST_IDLE);

   // R14: reads in idle return zero
   a_r14_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && state == ST_IDLE) |=> rd_data == '0);

   // R8: persistent status is only 00h or 01h
   a_r8_status_code: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && state == ST_PSTAT) |=> rd_data[DATA_W-1:1] == '0);

   // R11: no persistent bit rises while the lock holds
   a_r11_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> (ppb & ~$past(ppb)) == '0);

   // R12: the two mode locks never coexist
   a_r12_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwml && psml));

endmodule

bind flash_prot_seq fps_checker #(.DATA_W(DATA_W), .NSECT(1 << SECT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
   .rd_data(rd_data), .sec_wp(sec_wp), .state(seq_state), .ppb(ppb_vec),
   .lock(lock), .pwml(pwml), .psml(psml)
);

// File: tb/flash_prot_seq_tb.sv
module flash_prot_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [18:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [18:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic [255:0] sec_wp;

   int checks = 0;
   int failures = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        pend = 1'b0;

   localparam logic [10:0] WPL = 11'h03A;
   localparam logic [10:0] OWL = 11'h01A;
   localparam logic [10:0] PLL = 11'h00A;
   localparam logic [10:0] SLL = 11'h012;

   always #2 clk = ~clk;

   flash_prot_seq dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .sec_wp(sec_wp)
   );

   function automatic logic [18:0] ad(input int s, input logic [10:0] lo);
      logic [7:0] sv;
      sv = s[7:0];
      return {sv, lo};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [18:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [18:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wrrd(input logic [18:0] a, input logic [31:0] d,
                       input logic [18:0] ra, input logic [31:0] e, input string tag);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      rd_en = 1'b1; rd_addr = ra;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic unl(input logic [7:0] op);
      wr(ad(0, 11'h555), 32'h0000_00AA);
      wr(ad(0, 11'h2AA), 32'h0000_0055);
      wr(ad(0, 11'h555), {24'h0, op});
   endtask

   task automatic chk_wp(input int s, input logic e, input string tag);
      chk(tag, {31'b0, sec_wp[s]}, {31'b0, e});
   endtask

   always @(posedge clk) pend <= rd_en;

   always @(negedge clk) begin
      if (pend) begin
         if (exp_q.size() == 0) begin
            chk("R14 unexpected read", rd_data, 32'h0);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, rd_data, e);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R10 reset wp clear", sec_wp[31:0], 32'h0);
      rd(ad(0, WPL), 32'h0, "R14 idle read");

      // R5 program with same-cycle read
      unl(8'h60); wr(ad(3, WPL), 32'h68);
      wrrd(ad(3, WPL), 32'h48, ad(3, WPL), 32'h0, "R14 read before commit");
      chk_wp(3, 1'b1, "R10 wp after ppb set");
      rd(ad(3, WPL), 32'h1, "R6 verify set");

      // R5 address mismatch
      unl(8'h60); wr(ad(5, WPL), 32'h68); wr(ad(6, WPL), 32'h48);
      chk_wp(5, 1'b0, "R5 mismatch sector5");
      chk_wp(6, 1'b0, "R5 mismatch sector6");
      unl(8'h90);
      rd(ad(5, WPL), 32'h1, "R8 clear code");
      rd(ad(3, WPL), 32'h0, "R8 set code");

      // R1 broken prefix
      wr(ad(0, 11'h555), 32'hAA); wr(ad(0, 11'h555), 32'h55);
      wr(ad(0, 11'h555), 32'h48); wr(ad(7, 11'h0), 32'h1);
      chk_wp(7, 1'b0, "R1 bad prefix");

      // R2 high bits ignored
      wr({8'hFF, 11'h555}, 32'hABCD_12AA);
      wr({8'h80, 11'h2AA}, 32'hFFFF_FF55);
      wr({8'h3C, 11'h555}, 32'h0000_0148);
      wr(ad(7, 11'h0), 32'h1);
      chk_wp(7, 1'b1, "R2 dyb via wide prefix");

      // R9 dynamic status and clear with F0 operand
      unl(8'h58);
      rd(ad(7, 11'h0), 32'h1, "R9 dyb status set");
      rd(ad(6, 11'h0), 32'h0, "R9 dyb status clear");
      unl(8'h48); wr(ad(7, 11'h0), 32'h0000_00F0);
      chk_wp(7, 1'b0, "R9 dyb cleared by F0 operand");

      // R3 abort
      unl(8'h60); wr(ad(9, 11'h123), 32'hF0);
      wr(ad(2, WPL), 32'h68); wr(ad(2, WPL), 32'h48);
      chk_wp(2, 1'b0, "R3 abort discards");
      unl(8'h90);
      wrrd(ad(0, 11'h0), 32'hF0, ad(5, WPL), 32'h1, "R14 status before abort");
      rd(ad(5, WPL), 32'h0, "R3 idle after abort");

      // R7 erase all
      unl(8'h60); wr(ad(0, WPL), 32'h60); wr(ad(11, WPL), 32'h40);
      rd(ad(3, WPL), 32'h0, "R7 verify erased");
      chk_wp(3, 1'b0, "R7 wp after erase");

      // R4 secured bit, bit 2 ignored
      unl(8'h60); wr(ad(0, OWL), 32'h68); wr(ad(0, OWL), 32'h48);
      rd(ad(0, OWL), 32'h1, "R4 secured bit");
      rd(ad(0, 11'h01E), 32'h1, "R4 bit2 ignored");
      rd(ad(0, PLL), 32'h0, "R4 other target");

      // R11 lock
      unl(8'h60); wr(ad(1, WPL), 32'h68); wr(ad(1, WPL), 32'h48);
      chk_wp(1, 1'b1, "R5 sector1 set");
      unl(8'h78);
      unl(8'h60); wr(ad(4, WPL), 32'h68); wr(ad(4, WPL), 32'h48);
      chk_wp(4, 1'b0, "R11 program blocked");
      rd(ad(4, WPL), 32'h0, "R11 verify blocked");
      unl(8'h60); wr(ad(0, WPL), 32'h60); wr(ad(0, WPL), 32'h40);
      chk_wp(1, 1'b1, "R11 erase blocked");

      // R13 password program and verify
      unl(8'h38); wr(ad(0, 11'h0), 32'h1234_5678);
      unl(8'h38); wr(ad(0, 11'h1), 32'h9ABC_DEF0);
      unl(8'hC8);
      rd(ad(0, 11'h0), 32'h1234_5678, "R13 low half");
      rd(ad(0, 11'h1), 32'h9ABC_DEF0, "R3 F0 as password data");

      // R12 mode locks
      unl(8'h60); wr(ad(0, PLL), 32'h68); wr(ad(0, PLL), 32'h48);
      rd(ad(0, PLL), 32'h1, "R12 password mode set");
      unl(8'h60); wr(ad(0, SLL), 32'h68); wr(ad(0, SLL), 32'h48);
      rd(ad(0, SLL), 32'h0, "R12 other mode refused");
      unl(8'hC8);
      rd(ad(0, 11'h0), 32'h0, "R12 password hidden");
      unl(8'h38); wr(ad(0, 11'h0), 32'h0000_DEAD);

      // R13 unlock
      unl(8'h28); wr(ad(0, 11'h0), 32'h1111_1111);
      unl(8'h28); wr(ad(0, 11'h1), 32'h9ABC_DEF0);
      unl(8'h60); wr(ad(4, WPL), 32'h68); wr(ad(4, WPL), 32'h48);
      chk_wp(4, 1'b0, "R13 still locked");
      unl(8'h28); wr(ad(0, 11'h0), 32'h1234_5678);
      unl(8'h60); wr(ad(4, WPL), 32'h68); wr(ad(4, WPL), 32'h48);
      chk_wp(4, 1'b1, "R13 unlocked");

      repeat (4) @(negedge clk);
      chk("R14 all reads returned", 32'(exp_q.size()), 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule